// File: doc/BRIEF.md
# Two-Level Interrupt Combiner with Programmable Pin

This block collects single-cycle event pulses into a sticky status register. Software clears the register by writing ones. Each status bit has its own enable bit. A pending bit only raises a request when its enable bit and a global master gate are both set. The request drives a primary interrupt pin, and software chooses how that pin behaves:
- level or pulsed signalling;
- active-high or active-low polarity;
- on or off through a pin gate.

A second interrupt line comes from a neighbouring controller. It normally drives a secondary pin. A merge bit moves it onto the primary pin, so a system with one interrupt input can serve both controllers.

Software reaches three registers through a small port: a write strobe, a 2-bit address and a write data bus. Read data is returned combinationally for the current address. Only the primary pin is affected by the status, enable and master bits. Both pins share the same pin gate and the same signalling settings.

Top module: `irq_combiner`

## Requirements
- R1: An event pulse on `evt_i[i]` sets status bit i. The bit reads back as 1 at address 0 from the cycle after the pulse and stays set until software clears it.
- R2: A write to address 0 clears every status bit whose data bit is 1. Status bits written with 0 keep their value.
- R3: An event on bit i in the same cycle as a write that clears bit i leaves bit i set.
- R4: The primary request is the OR of (status AND enable, address 1), gated by the master bit. In level mode the primary pin shows the request one cycle after the request changes. An event whose enable bit is 0 never asserts the pin.
- R5: While the master bit (address 2, bit 0) is 0, pending enabled status does not assert the primary pin.
- R6: While the pin gate (address 2, bit 1) is 0, both pins sit at their inactive level for the selected polarity. The inactive level is high when active-low and low when active-high.
- R7: After reset the status, enable and configuration registers read 0. The pins are then in level mode, active low and gated off, so both pins are high.
- R8: The polarity bit (address 2, bit 3) selects the pin levels: 1 means asserted is high, 0 means asserted is low.
- R9: With the edge bit (address 2, bit 2) set, each rising edge of a pin's request gives exactly PULSE_W (4) asserted cycles, starting one cycle after the rise. After that the pin is inactive even if the request stays high.
- R10: With the merge bit (address 2, bit 4) at 0, `sec_irq_i` drives only the secondary pin. With it at 1, `sec_irq_i` is ORed into the primary request and the secondary pin stays inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | N_EVT | Event pulses, one per status bit |
| sec_irq_i | input | 1 | Interrupt request from the second controller (level) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 status, 1 enable, 2 configuration |
| wdata | input | N_EVT | Write data |
| rdata | output | N_EVT | Read data for `addr` |
| irq_a_o | output | 1 | Primary interrupt pin |
| irq_b_o | output | 1 | Secondary interrupt pin |

## Verification
The bench sweeps every event bit through the set, the write-0-keeps and the write-1-clears sequence, and it checks the pin in each polarity and trigger mode.

It targets specific wrong designs:
- **Clear wins over a same-cycle event.** The event would be lost, and status would read 0 after the collision write.
- **Gates dropped.** A design that ignored the master or enable gate, or that let a disabled pin float to the asserted level, would show the pin asserted with the gate off.
- **Wrong pulse length.** An off-by-one pulse counter, or a level leaking through in edge mode, would make the count of asserted cycles differ from four.
- **Merge routing inverted.** The secondary request would appear on the wrong pin.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_ENABLE = 2'd1;
  localparam logic [1:0] ADDR_CFG    = 2'd2;
  localparam int CFG_W = 5;

  typedef struct packed {
    logic merge;
    logic act_high;
    logic edge_mode;
    logic pin_en;
    logic master;
  } cfg_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [N_EVT-1:0] wdata,
  output logic [N_EVT-1:0] rdata,
  output logic [N_EVT-1:0] status_o,
  output logic [N_EVT-1:0] enable_o,
  output cfg_t             cfg_o
);
  logic [N_EVT-1:0] status_q, status_d;
  logic [N_EVT-1:0] enable_q, enable_d;
  cfg_t             cfg_q, cfg_d;
  logic             wr_status, wr_enable, wr_cfg;

  assign wr_status = wr_en && (addr == ADDR_STATUS);
  assign wr_enable = wr_en && (addr == ADDR_ENABLE);
  assign wr_cfg    = wr_en && (addr == ADDR_CFG);

  always_comb begin
    // Events take priority over a same-cycle clearing write
    status_d = wr_status ? ((status_q & ~wdata) | evt_i) : (status_q | evt_i);
    enable_d = wr_enable ? wdata : enable_q;
    cfg_d    = wr_cfg ? cfg_t'(wdata[CFG_W-1:0]) : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      cfg_q    <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      cfg_q    <= cfg_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_STATUS: rdata = status_q;
      ADDR_ENABLE: rdata = enable_q;
      ADDR_CFG:    rdata = {{(N_EVT-CFG_W){1'b0}}, cfg_q};
      default:     rdata = '0;
    endcase
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int PULSE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic pin_en_i,
  input  logic edge_i,
  input  logic act_high_i,
  output logic pin_o
);
  localparam int CW = $clog2(PULSE_W + 1);

  logic          req_q, req_d;
  logic          asrt_q, asrt_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise;

  assign rise = req_i && !req_q;

  always_comb begin
    req_d  = req_i;
    cnt_d  = cnt_q;
    asrt_d = 1'b0;
    if (!pin_en_i || !edge_i) begin
      cnt_d = '0;
    end else if (rise) begin
      cnt_d = CW'(PULSE_W - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (pin_en_i) begin
      asrt_d = edge_i ? (rise || (cnt_q != '0)) : req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      cnt_q  <= '0;
      asrt_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      cnt_q  <= cnt_d;
      asrt_q <= asrt_d;
    end
  end

  assign pin_o = act_high_i ? asrt_q : !asrt_q;
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_pkg::*;
#(
  parameter int N_EVT   = 8,
  parameter int PULSE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             sec_irq_i,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [N_EVT-1:0] wdata,
  output logic [N_EVT-1:0] rdata,
  output logic             irq_a_o,
  output logic             irq_b_o
);
  localparam int N_PINS = 2;

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic [N_EVT-1:0]  status_q, enable_q;
  cfg_t              cfg_q;
  logic              prim_req;
  logic [N_PINS-1:0] pin_req, pin_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  irq_regs #(.N_EVT(N_EVT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_i    (evt_i),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .status_o (status_q),
    .enable_o (enable_q),
    .cfg_o    (cfg_q)
  );

  assign prim_req   = cfg_q.master && (|(status_q & enable_q));
  assign pin_req[0] = prim_req || (cfg_q.merge && sec_irq_i);
  assign pin_req[1] = !cfg_q.merge && sec_irq_i;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    irq_pin_drv #(.PULSE_W(PULSE_W)) u_drv (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .req_i      (pin_req[g]),
      .pin_en_i   (cfg_q.pin_en),
      .edge_i     (cfg_q.edge_mode),
      .act_high_i (cfg_q.act_high),
      .pin_o      (pin_out[g])
    );
  end

  assign irq_a_o = pin_out[0];
  assign irq_b_o = pin_out[1];
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk
  import irq_pkg::*;
#(
  parameter int N_EVT   = 8,
  parameter int PULSE_W = 4
) (
  input logic             clk,
  input logic             rst_sn,
  input logic [N_EVT-1:0] evt_i,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [N_EVT-1:0] wdata,
  input logic [N_EVT-1:0] status,
  input cfg_t             cfg,
  input logic             irq_a_o,
  input logic             irq_b_o
);
  localparam int RW = $clog2(PULSE_W + 2) + 1;
  logic [RW-1:0] run_a;
  logic          asrt_a;

  assign asrt_a = cfg.act_high ? irq_a_o : !irq_a_o;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)                        run_a <= '0;
    else if (!cfg.edge_mode || !asrt_a) run_a <= '0;
    else if (run_a <= RW'(PULSE_W))     run_a <= run_a + 1'b1;
  end

  // R1: an event bit is set in status one cycle later
  p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (|evt_i) |=> ((status & $past(evt_i)) == $past(evt_i)));

  // R2: written ones clear when no event collides
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && addr == ADDR_STATUS && evt_i == '0) |=> ((status & $past(wdata)) == '0));

  // R2: bits written with zero keep their value
  p_w0_keep_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && addr == ADDR_STATUS) |=> ((status & ~$past(wdata)) == ($past(status) & ~$past(wdata))));

  // R5: master off in level mode keeps the primary pin idle (no merge)
  p_master_gate_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cfg.master && !cfg.merge && !cfg.edge_mode) |=> (irq_a_o == !cfg.act_high));

  // R6: pin gate off keeps both pins inactive
  p_pin_off_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cfg.pin_en) |=> (irq_a_o == !cfg.act_high && irq_b_o == !cfg.act_high));

  // R9: edge mode pulses never exceed PULSE_W cycles
  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    run_a <= RW'(PULSE_W));

  // R10: merged secondary pin stays inactive in level mode
  p_merge_b_idle_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (cfg.merge && !cfg.edge_mode) |=> (irq_b_o == !cfg.act_high));
endmodule

bind irq_combiner irq_combiner_chk #(.N_EVT(N_EVT), .PULSE_W(PULSE_W)) u_chk (
  .clk     (clk),
  .rst_sn  (rst_sync_n),
  .evt_i   (evt_i),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .status  (status_q),
  .cfg     (cfg_q),
  .irq_a_o (irq_a_o),
  .irq_b_o (irq_b_o)
);

// File: tb/sim_irq_combiner.sv
module sim_irq_combiner;
  localparam int N = 8;
  localparam int PW = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         sec_irq_i = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq_a_o, irq_b_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_combiner #(.N_EVT(N), .PULSE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sec_irq_i(sec_irq_i),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
  );

  function automatic logic lvl(input logic asserted, input logic act_high);
    return act_high ? asserted : !asserted;
  endfunction

  function automatic logic [N-1:0] cfgv(input logic merge, input logic ah,
                                        input logic edg, input logic pe, input logic m);
    return {{(N-5){1'b0}}, merge, ah, edg, pe, m};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    evt_i = v;
    tick();
    evt_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    int cnt;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R7 reset state
    rd(2'd0, v); check("R7 status", v, 0);
    rd(2'd1, v); check("R7 enable", v, 0);
    rd(2'd2, v); check("R7 config", v, 0);
    check("R7 pin a", irq_a_o, 1);
    check("R7 pin b", irq_b_o, 1);

    wr(2'd1, '1);
    wr(2'd2, cfgv(0, 0, 0, 1, 1));
    tick();
    check("R4 idle pin", irq_a_o, 1);

    for (int i = 0; i < N; i++) begin
      pulse(N'(1) << i);
      rd(2'd0, v); check("R1 status set", v, 1 << i);
      tick();
      check("R4 level asserted", irq_a_o, lvl(1, 0));
      wr(2'd0, ~(N'(1) << i));
      rd(2'd0, v); check("R2 write zero keeps", v, 1 << i);
      wr(2'd0, N'(1) << i);
      rd(2'd0, v); check("R2 write one clears", v, 0);
      tick();
      check("R4 level released", irq_a_o, lvl(0, 0));
    end

    // R4 enable gate
    wr(2'd1, 8'hFE);
    pulse(8'h01); tick(); tick();
    check("R4 disabled bit no pin", irq_a_o, 1);
    rd(2'd0, v); check("R1 disabled bit still recorded", v, 8'h01);
    wr(2'd0, 8'h01);
    wr(2'd1, '1);

    // R3 collision
    pulse(8'h04);
    evt_i = 8'h08; wr_en = 1'b1; addr = 2'd0; wdata = 8'h0C;
    tick();
    evt_i = '0; wr_en = 1'b0;
    rd(2'd0, v); check("R3 event beats clear", v, 8'h08);
    wr(2'd0, 8'h08); tick();

    // R5 master gate
    wr(2'd2, cfgv(0, 0, 0, 1, 0));
    pulse(8'h10); tick(); tick();
    check("R5 master off", irq_a_o, 1);
    wr(2'd2, cfgv(0, 0, 0, 1, 1));
    tick();
    check("R5 master on", irq_a_o, 0);

    // R6 pin gate, both polarities, request pending
    for (int p = 0; p < 2; p++) begin
      wr(2'd2, cfgv(0, p[0], 0, 0, 1));
      tick();
      check("R6 pin a gated", irq_a_o, lvl(0, p[0]));
      check("R6 pin b gated", irq_b_o, lvl(0, p[0]));
    end

    // R8 active high
    wr(2'd2, cfgv(0, 1, 0, 1, 1));
    tick();
    check("R8 active high asserted", irq_a_o, 1);
    wr(2'd0, 8'h10); tick();
    check("R8 active high idle", irq_a_o, 0);

    // R9 edge mode pulse count
    for (int p = 0; p < 2; p++) begin
      wr(2'd2, cfgv(0, p[0], 1, 1, 1));
      tick();
      pulse(8'h20);
      cnt = 0;
      for (int k = 0; k < 10; k++) begin
        tick();
        if (irq_a_o == lvl(1, p[0])) cnt++;
      end
      check("R9 pulse width", cnt, PW);
      check("R9 idle after pulse", irq_a_o, lvl(0, p[0]));
      wr(2'd0, 8'h20); tick();
    end

    // R10 merge routing
    wr(2'd2, cfgv(0, 0, 0, 1, 1));
    sec_irq_i = 1'b1; tick(); tick();
    check("R10 unmerged b", irq_b_o, 0);
    check("R10 unmerged a", irq_a_o, 1);
    wr(2'd2, cfgv(1, 0, 0, 1, 1));
    tick();
    check("R10 merged a", irq_a_o, 0);
    check("R10 merged b", irq_b_o, 1);
    sec_irq_i = 1'b0; tick(); tick();
    check("R10 merged release", irq_a_o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule